// File: doc/BRIEF.md
# Power-On Boot Sequencer with Boot-Region Remap

This block brings a small processor system out of power-on reset. Once the external reset is released, it waits for a clock-ready indication. It then counts out a fixed settling interval and reads the first words of user flash through a dedicated read port. From the strap pin and the contents of those words, it decides whether the core boots from the user application bank or from the bootloader bank. Only after that decision is made does it release the core's reset.

While the core runs, the block sits on the core's fetch path as an address decoder. Addresses with the alias bit clear fall in the low boot region and are steered to the chosen bank. Addresses with the alias bit set always reach the user bank directly. When the user bank is chosen, the same word is therefore visible at two addresses. The core's first access, a vector read at address zero, lands in whichever bank was chosen. The flash arrays and the core are outside the block.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst_n` is low, `core_rst_n`, `chk_rd`, `b0_rd` and `b1_rd` are all 0, and `cpu_rdata` is 0.
- R2: After reset release, the block waits in a held state (`core_rst_n` = 0, no check reads) for as long as `clk_ok` stays low.
- R3: The first clock edge with `clk_ok` high starts a settle interval of exactly `SETTLE_CYCLES` cycles, during which nothing is read. The first check read follows immediately after it.
- R4: Check reads cover word indices 0 to `CHECK_WORDS`-1, one per cycle in ascending order. The byte address on `chk_addr` is 4 × index. `chk_rd` is high in exactly those cycles.
- R5: The bootloader bank (bank 1) is chosen when `strap_i` = 1 at the last check cycle. It is also chosen when any checked word equals all ones. Otherwise the user bank (bank 0) is chosen.
- R6: Exactly one cycle, with no read and the core still held, separates the last check read from `core_rst_n` going high. `core_rst_n` then stays high until `rst_n` falls.
- R7: While the core runs, a read with address bit `ADDR_W`-1 clear goes to the chosen bank. The bank offset is the low `ADDR_W`-1 address bits. `cpu_rdata` returns that bank's data in the same cycle, and at most one bank strobe is high.
- R8: While the core runs, a read with address bit `ADDR_W`-1 set always goes to bank 0 at the low-bit offset, whatever was chosen.
- R9: While `core_rst_n` is 0, no bank strobe is raised and `cpu_rdata` is 0, even if `cpu_rd` is high.
- R10: Changing `strap_i` or the user flash contents after the core is running does not change the bank that serves the boot region.
- R11: Pulling `rst_n` low in any state returns the block to the R1 condition at once. A later release reruns the whole sequence and makes a fresh boot choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| clk_ok | input | 1 | Clock has settled |
| strap_i | input | 1 | Boot strap: 1 requests the bootloader bank |
| chk_rd | output | 1 | Check read strobe to user flash |
| chk_addr | output | ADDR_W-1 | Byte address of the check read |
| chk_data | input | DATA_W | User flash word for `chk_addr`, same cycle |
| core_rst_n | output | 1 | Core reset, active low |
| cpu_rd | input | 1 | Core fetch/read request |
| cpu_addr | input | ADDR_W | Core byte address |
| cpu_rdata | output | DATA_W | Data returned to the core |
| b0_rd | output | 1 | User bank read strobe |
| b0_addr | output | ADDR_W-1 | User bank byte offset |
| b0_rdata | input | DATA_W | User bank data, same cycle |
| b1_rd | output | 1 | Bootloader bank read strobe |
| b1_addr | output | ADDR_W-1 | Bootloader bank byte offset |
| b1_rdata | input | DATA_W | Bootloader bank data, same cycle |

## Verification
A sequencer stuck or miscounted shows first on `chk_rd` and `chk_addr`, and the bench catches it in the cycle where the first check read lands early, late or at the wrong index. A wrong `core_rst_n` edge is seen in the cycle it happens. A wrong boot choice is silent until the core reads the boot region. The bench therefore fetches address zero right after release, under each strap and flash pattern. It also issues fetches while the core is held, so that a decoder that ignores the hold shows a stray strobe at once.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_WAIT_CLK,
    ST_SETTLE,
    ST_CHECK,
    ST_RELEASE,
    ST_RUN
  } boot_state_e;

  // an erased flash word reads back as all ones
  function automatic logic word_is_erased(input logic [63:0] w, input int unsigned width);
    logic all1;
    all1 = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i < width && !w[i]) all1 = 1'b0;
    end
    return all1;
  endfunction

  // check word index to byte offset (32-bit words)
  function automatic int unsigned word_byte_offset(input int unsigned idx);
    return idx * 4;
  endfunction

  // bank 1 serves a fetch only in the boot region when the bootloader was chosen
  function automatic logic route_to_alt(input logic direct_bit, input logic boot_alt);
    return !direct_bit && boot_alt;
  endfunction

endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int CHECK_WORDS   = 2,
  parameter int DATA_W        = 32,
  parameter int OFS_W         = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_ok,
  input  logic              strap_i,
  output logic              chk_rd,
  output logic [OFS_W-1:0]  chk_addr,
  input  logic [DATA_W-1:0] chk_data,
  output logic              core_run,
  output logic              boot_alt
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES) + 1;
  localparam int IDX_W = $clog2(CHECK_WORDS) + 1;

  boot_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             blank_q;
  logic             alt_q;

  // named internal events
  logic settle_done;
  logic last_chk;
  logic word_blank;

  assign settle_done = (st_q == ST_SETTLE) && (cnt_q == CNT_W'(SETTLE_CYCLES - 1));
  assign last_chk    = (st_q == ST_CHECK) && (idx_q == IDX_W'(CHECK_WORDS - 1));
  assign chk_rd      = (st_q == ST_CHECK);
  assign chk_addr    = OFS_W'(word_byte_offset(32'(idx_q)));
  assign word_blank  = chk_rd && word_is_erased(64'(chk_data), DATA_W);
  assign core_run    = (st_q == ST_RUN);
  assign boot_alt    = alt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RESET:    st_d = ST_WAIT_CLK;
      ST_WAIT_CLK: if (clk_ok) st_d = ST_SETTLE;
      ST_SETTLE:   if (settle_done) st_d = ST_CHECK;
      ST_CHECK:    if (last_chk) st_d = ST_RELEASE;
      ST_RELEASE:  st_d = ST_RUN;
      ST_RUN:      st_d = ST_RUN;
      default:     st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RESET;
      cnt_q   <= '0;
      idx_q   <= '0;
      blank_q <= 1'b0;
      alt_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= (st_q == ST_SETTLE) ? cnt_q + 1'b1 : '0;
      idx_q   <= (st_q == ST_CHECK) ? idx_q + 1'b1 : '0;
      blank_q <= (st_q == ST_CHECK) ? (blank_q | word_blank) : 1'b0;
      if (last_chk) alt_q <= strap_i | blank_q | word_blank;
    end
  end

  // assertions
  assert_reset_hold_R1: assert property (@(posedge clk) !rst_n |-> (!core_run && !chk_rd));
  assert_wait_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_CLK && !clk_ok) |=> (st_q == ST_WAIT_CLK));
  assert_settle_then_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |=> (chk_rd && chk_addr == '0));
  assert_gap_before_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_chk |=> (!chk_rd && !core_run));
  assert_run_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> core_run);
  assert_choice_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> $stable(boot_alt));
  assert_no_check_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_rd |-> !core_run);

endmodule

// File: rtl/boot_seq_remap.sv
module boot_seq_remap
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_run,
  input  logic              boot_alt,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              b0_rd,
  output logic [ADDR_W-2:0] b0_addr,
  input  logic [DATA_W-1:0] b0_rdata,
  output logic              b1_rd,
  output logic [ADDR_W-2:0] b1_addr,
  input  logic [DATA_W-1:0] b1_rdata
);
  localparam int DIRECT_BIT = ADDR_W - 1;

  logic pick_alt;
  logic direct_hit;

  assign direct_hit = cpu_addr[DIRECT_BIT];
  assign pick_alt   = route_to_alt(direct_hit, boot_alt);
  assign b0_addr    = cpu_addr[DIRECT_BIT-1:0];
  assign b1_addr    = cpu_addr[DIRECT_BIT-1:0];
  assign b0_rd      = core_run && cpu_rd && !pick_alt;
  assign b1_rd      = core_run && cpu_rd && pick_alt;

  always_comb begin
    if (!core_run) cpu_rdata = '0;
    else if (pick_alt) cpu_rdata = b1_rdata;
    else cpu_rdata = b0_rdata;
  end

  // assertions
  assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({b0_rd, b1_rd}));
  assert_direct_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && cpu_rd && direct_hit) |-> (b0_rd && !b1_rd));
  assert_held_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |-> (!b0_rd && !b1_rd && cpu_rdata == '0));

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top #(
  parameter int SETTLE_CYCLES = 16,
  parameter int CHECK_WORDS   = 2,
  parameter int ADDR_W        = 25,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_ok,
  input  logic              strap_i,
  output logic              chk_rd,
  output logic [ADDR_W-2:0] chk_addr,
  input  logic [DATA_W-1:0] chk_data,
  output logic              core_rst_n,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              b0_rd,
  output logic [ADDR_W-2:0] b0_addr,
  input  logic [DATA_W-1:0] b0_rdata,
  output logic              b1_rd,
  output logic [ADDR_W-2:0] b1_addr,
  input  logic [DATA_W-1:0] b1_rdata
);
  localparam int OFS_W = ADDR_W - 1;

  logic core_run;
  logic boot_alt;

  boot_seq_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .CHECK_WORDS  (CHECK_WORDS),
    .DATA_W       (DATA_W),
    .OFS_W        (OFS_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_ok  (clk_ok),
    .strap_i (strap_i),
    .chk_rd  (chk_rd),
    .chk_addr(chk_addr),
    .chk_data(chk_data),
    .core_run(core_run),
    .boot_alt(boot_alt)
  );

  boot_seq_remap #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) remap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_run (core_run),
    .boot_alt (boot_alt),
    .cpu_rd   (cpu_rd),
    .cpu_addr (cpu_addr),
    .cpu_rdata(cpu_rdata),
    .b0_rd    (b0_rd),
    .b0_addr  (b0_addr),
    .b0_rdata (b0_rdata),
    .b1_rd    (b1_rd),
    .b1_addr  (b1_addr),
    .b1_rdata (b1_rdata)
  );

  assign core_rst_n = core_run;

endmodule

// File: tb/boot_seq_top_tb_top.sv
`timescale 1ns/1ps
module boot_seq_top_tb_top;
  localparam int S  = 16;
  localparam int W  = 2;
  localparam int AW = 25;
  localparam int DW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic clk_ok = 0;
  logic strap_i = 0;
  logic chk_rd;
  logic [AW-2:0] chk_addr;
  logic [DW-1:0] chk_data;
  logic core_rst_n;
  logic cpu_rd = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_rdata;
  logic b0_rd, b1_rd;
  logic [AW-2:0] b0_addr, b1_addr;
  logic [DW-1:0] b0_rdata, b1_rdata;

  logic [DW-1:0] uw0 = 32'h2000_1000;
  logic [DW-1:0] uw1 = 32'h0000_0101;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] f0(input logic [AW-2:0] a);
    if (a == 0) return uw0;
    if (a == 4) return uw1;
    return {8'hA5, a};
  endfunction

  function automatic logic [DW-1:0] f1(input logic [AW-2:0] a);
    return {8'h5B, a} ^ 32'h0000_0F0F;
  endfunction

  assign chk_data = f0(chk_addr);
  assign b0_rdata = f0(b0_addr);
  assign b1_rdata = f1(b1_addr);

  boot_seq_top #(.SETTLE_CYCLES(S), .CHECK_WORDS(W), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .strap_i(strap_i),
    .chk_rd(chk_rd), .chk_addr(chk_addr), .chk_data(chk_data),
    .core_rst_n(core_rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
    .b0_rd(b0_rd), .b0_addr(b0_addr), .b0_rdata(b0_rdata),
    .b1_rd(b1_rd), .b1_addr(b1_addr), .b1_rdata(b1_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: phase -1 reset, 0 waiting for clock, 1 timeline with tick k
  int phase = -1;
  int k = 0;
  bit exp_alt = 0;

  function automatic bit m_run();
    return phase == 1 && k >= S + W + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = -1; k = 0;
    end else if (phase == -1) begin
      phase = 0;
    end else if (phase == 0) begin
      if (clk_ok) begin phase = 1; k = 0; end
    end else begin
      if (k == S + W - 1)
        exp_alt = strap_i | (uw0 == 32'hFFFF_FFFF) | (uw1 == 32'hFFFF_FFFF);
      if (k < S + W + 5) k++;
    end
    #2;
    begin
      bit run_e, chk_e, alt_e;
      logic [DW-1:0] data_e;
      run_e = m_run();
      chk_e = (phase == 1) && (k >= S) && (k < S + W);
      alt_e = run_e && cpu_rd && !cpu_addr[AW-1] && exp_alt;
      data_e = !run_e ? '0 : (alt_e ? f1(cpu_addr[AW-2:0]) : f0(cpu_addr[AW-2:0]));
      check(core_rst_n == run_e, phase == -1 ? "R1 core_rst_n" : "R6 core_rst_n", core_rst_n, run_e);
      check(chk_rd == chk_e, phase == 0 ? "R2 chk_rd" : "R3 chk_rd timing", chk_rd, chk_e);
      if (chk_e) check(chk_addr == AW'(4 * (k - S)), "R4 chk_addr", chk_addr, 4 * (k - S));
      check(b1_rd == alt_e, run_e ? "R7 b1_rd" : "R9 b1_rd", b1_rd, alt_e);
      check(b0_rd == (run_e && cpu_rd && !alt_e), run_e ? "R8 b0_rd" : "R9 b0_rd", b0_rd, run_e && cpu_rd && !alt_e);
      check(cpu_rdata == data_e, run_e ? "R7 cpu_rdata" : "R9 cpu_rdata", cpu_rdata, data_e);
    end
  end

  task automatic wait_run();
    for (int i = 0; i < 200 && !core_rst_n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fetch(input logic [AW-1:0] a, input bit alt_bank, input string req);
    logic [DW-1:0] e;
    @(negedge clk);
    cpu_rd = 1; cpu_addr = a;
    @(posedge clk); #3;
    e = alt_bank ? f1(a[AW-2:0]) : f0(a[AW-2:0]);
    check(cpu_rdata == e, req, cpu_rdata, e);
  endtask

  task automatic do_reset(input int cyc);
    @(negedge clk);
    rst_n = 0;
    #1;
    check(core_rst_n == 0 && chk_rd == 0, "R11 immediate hold", {core_rst_n, chk_rd}, 0);
    repeat (cyc) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cpu_rd = 1; cpu_addr = '0;
    repeat (4) @(negedge clk);
    check(core_rst_n == 0 && b0_rd == 0 && b1_rd == 0, "R1 reset outputs", {core_rst_n, b0_rd, b1_rd}, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check(core_rst_n == 0 && chk_rd == 0, "R2 held without clk_ok", {core_rst_n, chk_rd}, 0);
    check(b0_rd == 0 && cpu_rdata == 0, "R9 fetch while held", cpu_rdata, 0);
    clk_ok = 1;
    wait_run();
    // normal user boot
    fetch(25'h000_0000, 0, "R7 vector word user bank");
    fetch(25'h000_0004, 0, "R7 reset address word");
    fetch(25'h100_0000, 0, "R8 direct alias of word 0");
    fetch(25'h000_0340, 0, "R7 plain offset");
    // strap and flash change after run
    @(negedge clk); strap_i = 1; uw0 = 32'hFFFF_FFFF;
    fetch(25'h000_0100, 0, "R10 strap after run ignored");
    uw0 = 32'h2000_1000;
    // reboot with strap set: bootloader
    do_reset(3);
    wait_run();
    fetch(25'h000_0000, 1, "R5 strap selects bootloader");
    fetch(25'h000_0abc, 1, "R7 boot region to bank 1");
    fetch(25'h100_0000, 0, "R8 direct goes to user bank");
    // strap clear but erased vector word
    strap_i = 0; uw1 = 32'hFFFF_FFFF;
    do_reset(2);
    wait_run();
    fetch(25'h000_0000, 1, "R5 blank word forces bootloader");
    fetch(25'h100_0008, 0, "R8 direct with bootloader chosen");
    uw1 = 32'h0000_0101;
    // reset during settle, then clean user boot
    do_reset(2);
    repeat (6) @(negedge clk);
    do_reset(1);
    wait_run();
    fetch(25'h000_0000, 0, "R11 rerun picks user bank");
    @(negedge clk); cpu_rd = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule